// File: doc/BRIEF.md
# Edge/Level Interrupt Controller

The block collects a vector of interrupt inputs and turns each one into a request according to a per-source trigger code. The code selects one of several behaviours. Disabled ignores the input. Rising, falling and both-edge modes catch events in sticky latches. Level-high and level-low modes follow the synchronised input directly. A qualified source that is also enabled by its mask bit is steered by its assign bit onto one of two request lines. Line 0 is the higher-priority line. A separate wake output reports qualified sources whose wake-enable bit is set, whether or not their mask bit is set.

Software programs the block through a small register port. Every register has a set address, a clear address and a read-back address. Each bit of a write-1 address acts on one source, and zero bits leave the register unchanged. Two read-only views show which sources are pending on each request line. When the interrupt handler reads one of these views and finds zero, it treats the request as spurious. The number of sources is a parameter and defaults to 32.

Top module: `edge_level_intc`

## Requirements
- R1: The address is {index[3:0], op[1:0]}. Op 1 ORs the write data into the register and op 2 clears the bits that are 1 in the data. Op 0 is the read-back address and writes to it change nothing. Zero data bits leave the register unchanged. The register indices are: 0 code bit0, 1 code bit1, 2 code bit2, 3 mask, 4 assign, 5 wake, 6 source-select, 7 test, 8 rising latch, 9 falling latch, 10 pending on line 0, 11 pending on line 1. A read returns the selected register only when op is 0. Other reads return 0.
- R2: The trigger code for each source is {bit2, bit1, bit0}. 000 is disabled, 001 rising edge, 010 falling edge, 011 both edges, 101 level-high and 110 level-low. The codes 100 and 111 never qualify the source.
- R3: A rising latch bit is captured only when bit2 is 0 and bit0 is 1. A falling latch bit is captured only when bit2 is 0 and bit1 is 1. The two latches are separate. Each latch bit stays set until software writes 1 to its clear address (op 2). Set writes to the latches have no effect.
- R4: A qualified and unmasked source with assign 1 is pending on line 0, and with assign 0 it is pending on line 1. req0_o is the OR of the line-0 pending bits and req1_o is the OR of the line-1 pending bits.
- R5: A source whose mask bit is 0 is never pending on either line.
- R6: Register indices 10 and 11 read back the line-0 and line-1 pending vectors. Each view reads 0 when nothing is pending on that line.
- R7: wake_o is high when any qualified source has its wake bit set, independent of its mask bit.
- R8: After reset, all registers read 0 and req0_o, req1_o and wake_o are low.
- R9: When an edge capture and a clear write hit the same latch bit in the same cycle, the bit ends up set.
- R10: Inputs pass through a two-flop synchroniser. A level-mode request appears two clock edges after the input change. An edge-mode request appears three clock edges after the input change.
- R11: The source-select register is plain storage across all bits. The test register is one bit at data bit 0, and reads return it in bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| irq_i | input | NSRC | Asynchronous interrupt source inputs |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 6 | Write address {index, op} |
| wr_data_i | input | NSRC | Write data, one bit per source |
| rd_addr_i | input | 6 | Read address {index, op} |
| rd_data_o | output | NSRC | Combinational read data |
| req0_o | output | 1 | Request line 0, the higher-priority line |
| req1_o | output | 1 | Request line 1 |
| wake_o | output | 1 | Wake request |

## Verification
The hardest case to reach from the ports is a clear write that lands in exactly the cycle an edge is captured. The bench counts the synchroniser and latch stages from the input change and places the clear write on the capture edge, then reads the latch back. It also sweeps every source position through all eight trigger codes with both assign values. In each sweep step the input rises and falls, and the rising latch is cleared between the two changes. This shows that the edge modes forget and the level modes persist.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 6;
  localparam int NCTRL  = 7;

  typedef enum logic [3:0] {
    RI_CFG0   = 4'd0,
    RI_CFG1   = 4'd1,
    RI_CFG2   = 4'd2,
    RI_MASK   = 4'd3,
    RI_ASSIGN = 4'd4,
    RI_WAKE   = 4'd5,
    RI_SRCSEL = 4'd6,
    RI_TEST   = 4'd7,
    RI_RISE   = 4'd8,
    RI_FALL   = 4'd9,
    RI_PEND0  = 4'd10,
    RI_PEND1  = 4'd11
  } reg_idx_e;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_RSVD = 2'd3
  } reg_op_e;
endpackage

// File: rtl/intc_rst_sync.sv
module intc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end
endmodule

// File: rtl/intc_sc_reg.sv
module intc_sc_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_n;
  logic         en;

  always_comb begin
    en  = (|set_i) | (|clr_i);
    q_n = (q_o | set_i) & ~clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_o <= '0;
    else if (en) q_o <= q_n;
  end
endmodule

// File: rtl/intc_sync.sv
module intc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_o  <= '0;
      prev_o <= '0;
    end else begin
      meta_q <= async_i;
      cur_o  <= meta_q;
      prev_o <= cur_o;
    end
  end
endmodule

// File: rtl/intc_trigger.sv
module intc_trigger #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] code0_i,
  input  logic [W-1:0] code1_i,
  input  logic [W-1:0] code2_i,
  input  logic [W-1:0] cur_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] rise_clr_i,
  input  logic [W-1:0] fall_clr_i,
  output logic [W-1:0] rise_q_o,
  output logic [W-1:0] fall_q_o,
  output logic [W-1:0] active_o
);
  logic [W-1:0] edge_mode, lvl_hi, lvl_lo;
  logic [W-1:0] rise_cap, fall_cap, rise_n, fall_n;
  logic         en;

  always_comb begin
    edge_mode = ~code2_i;
    lvl_hi    = code2_i & ~code1_i &  code0_i;
    lvl_lo    = code2_i &  code1_i & ~code0_i;
    rise_cap  = cur_i & ~prev_i & edge_mode & code0_i;
    fall_cap  = ~cur_i & prev_i & edge_mode & code1_i;
    // a capture in the same cycle as a clear keeps the bit set
    rise_n    = (rise_q_o & ~rise_clr_i) | rise_cap;
    fall_n    = (fall_q_o & ~fall_clr_i) | fall_cap;
    en        = (|rise_cap) | (|fall_cap) | (|rise_clr_i) | (|fall_clr_i);
    active_o  = (lvl_hi & cur_i) | (lvl_lo & ~cur_i) |
                (edge_mode & ((code0_i & rise_q_o) | (code1_i & fall_q_o)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q_o <= '0;
      fall_q_o <= '0;
    end else if (en) begin
      rise_q_o <= rise_n;
      fall_q_o <= fall_n;
    end
  end
endmodule

// File: rtl/edge_level_intc.sv
module edge_level_intc
  import intc_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   irq_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [NSRC-1:0]   wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [NSRC-1:0]   rd_data_o,
  output logic              req0_o,
  output logic              req1_o,
  output logic              wake_o
);
  logic              rst_sync_n;
  logic [3:0]        wr_idx, rd_idx;
  logic [1:0]        wr_op, rd_op;
  logic [NSRC-1:0]   ctrl_q [NCTRL];
  logic [NSRC-1:0]   mask_q, assign_q, wake_q;
  logic [NSRC-1:0]   cur, prev, rise_q, fall_q, active;
  logic [NSRC-1:0]   rise_clr, fall_clr, pend0, pend1;
  logic              test_q, test_set, test_clr;

  assign wr_idx = wr_addr_i[5:2];
  assign wr_op  = wr_addr_i[1:0];
  assign rd_idx = rd_addr_i[5:2];
  assign rd_op  = rd_addr_i[1:0];

  intc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  for (genvar r = 0; r < NCTRL; r++) begin : g_ctrl
    logic [NSRC-1:0] set_v, clr_v;
    assign set_v = (wr_en_i && wr_idx == 4'(r) && wr_op == OP_SET) ? wr_data_i : '0;
    assign clr_v = (wr_en_i && wr_idx == 4'(r) && wr_op == OP_CLR) ? wr_data_i : '0;
    intc_sc_reg #(.W(NSRC)) u_reg (
      .clk(clk), .rst_n(rst_sync_n), .set_i(set_v), .clr_i(clr_v), .q_o(ctrl_q[r])
    );
  end

  assign test_set = wr_en_i && wr_idx == RI_TEST && wr_op == OP_SET && wr_data_i[0];
  assign test_clr = wr_en_i && wr_idx == RI_TEST && wr_op == OP_CLR && wr_data_i[0];

  intc_sc_reg #(.W(1)) u_test (
    .clk(clk), .rst_n(rst_sync_n), .set_i(test_set), .clr_i(test_clr), .q_o(test_q)
  );

  assign mask_q   = ctrl_q[int'(RI_MASK)];
  assign assign_q = ctrl_q[int'(RI_ASSIGN)];
  assign wake_q   = ctrl_q[int'(RI_WAKE)];
  assign rise_clr = (wr_en_i && wr_idx == RI_RISE && wr_op == OP_CLR) ? wr_data_i : '0;
  assign fall_clr = (wr_en_i && wr_idx == RI_FALL && wr_op == OP_CLR) ? wr_data_i : '0;

  intc_sync #(.W(NSRC)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .async_i(irq_i), .cur_o(cur), .prev_o(prev)
  );

  intc_trigger #(.W(NSRC)) u_trig (
    .clk(clk), .rst_n(rst_sync_n),
    .code0_i(ctrl_q[int'(RI_CFG0)]), .code1_i(ctrl_q[int'(RI_CFG1)]),
    .code2_i(ctrl_q[int'(RI_CFG2)]),
    .cur_i(cur), .prev_i(prev), .rise_clr_i(rise_clr), .fall_clr_i(fall_clr),
    .rise_q_o(rise_q), .fall_q_o(fall_q), .active_o(active)
  );

  always_comb begin
    pend0  = active & mask_q & assign_q;
    pend1  = active & mask_q & ~assign_q;
    req0_o = |pend0;
    req1_o = |pend1;
    wake_o = |(active & wake_q);
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_op == OP_READ) begin
      case (rd_idx)
        RI_CFG0, RI_CFG1, RI_CFG2, RI_MASK, RI_ASSIGN, RI_WAKE, RI_SRCSEL:
                   rd_data_o = ctrl_q[rd_idx[2:0]];
        RI_TEST:   rd_data_o = {{(NSRC-1){1'b0}}, test_q};
        RI_RISE:   rd_data_o = rise_q;
        RI_FALL:   rd_data_o = fall_q;
        RI_PEND0:  rd_data_o = pend0;
        RI_PEND1:  rd_data_o = pend1;
        default:   rd_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int NSRC = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [5:0]      wr_addr,
  input logic [NSRC-1:0] wr_data,
  input logic [NSRC-1:0] mask,
  input logic [NSRC-1:0] pend0,
  input logic [NSRC-1:0] pend1,
  input logic [NSRC-1:0] rise_lat,
  input logic [NSRC-1:0] rise_clr,
  input logic            req0,
  input logic            req1
);
  p_reset_quiet_r8: assert property (@(posedge clk) !rst_n |-> (!req0 && !req1));

  p_route_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend0 & pend1) == '0);

  p_mask_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend0 | pend1) & ~mask) == '0);

  p_mask_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 6'b0011_01) |=> ((mask & $past(wr_data)) == $past(wr_data)));

  p_latch_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(rise_lat) & ~$past(rise_clr) & ~rise_lat) == '0));
endmodule

bind edge_level_intc intc_chk #(.NSRC(NSRC)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
  .wr_data(wr_data_i), .mask(mask_q), .pend0(pend0), .pend1(pend1),
  .rise_lat(rise_q), .rise_clr(rise_clr), .req0(req0_o), .req1(req1_o)
);

// File: tb/edge_level_intc_tb_top.sv
`timescale 1ns/1ps
module edge_level_intc_tb_top;
  localparam int N = 8;
  localparam logic [3:0] I_C0 = 0, I_C1 = 1, I_C2 = 2, I_MASK = 3, I_ASG = 4,
                         I_WAKE = 5, I_SSEL = 6, I_TEST = 7, I_RISE = 8,
                         I_FALL = 9, I_P0 = 10, I_P1 = 11;
  localparam logic [1:0] RD = 0, ST = 1, CL = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic         wr_en = 1'b0;
  logic [5:0]   wr_addr = '0;
  logic [N-1:0] wr_data = '0;
  logic [5:0]   rd_addr = '0;
  logic [N-1:0] rd_data;
  logic         req0, req1, wake;
  int           n_chk = 0;
  int           n_bad = 0;
  bit           done = 1'b0;

  always #5 clk = ~clk;

  edge_level_intc #(.NSRC(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .req0_o(req0), .req1_o(req1), .wake_o(wake)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] idx, input logic [1:0] op, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {idx, op}; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [N-1:0] v);
    rd_addr = {idx, RD};
    #1;
    v = rd_data;
  endtask

  function automatic bit exp_act(input int code, input bit lvl, input bit rs, input bit fs);
    case (code)
      1: return rs;
      2: return fs;
      3: return rs | fs;
      5: return lvl;
      6: return !lvl;
      default: return 1'b0;
    endcase
  endfunction

  task automatic sweep_check(input int s, input int c, input bit a,
                             input bit lvl, input bit rs, input bit fs, input string ph);
    logic [N-1:0] p0, p1;
    bit e;
    e = exp_act(c, lvl, rs, fs);
    rd(I_P0, p0);
    rd(I_P1, p1);
    check($sformatf("R2 R4 R6 src%0d code%0d asg%0d %s", s, c, a, ph),
          {14'd0, req0, req1, p0, p1},
          {14'd0, a & e, !a & e, (a & e) ? N'(1 << s) : N'(0),
           (!a & e) ? N'(1 << s) : N'(0)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %h expected %h", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 reset state
    for (int i = 0; i < 12; i++) begin
      rd(4'(i), v);
      check($sformatf("R8 reg%0d after reset", i), 32'(v), 0);
    end
    check("R8 outputs after reset", {29'd0, req0, req1, wake}, 0);

    // R1 set/clear semantics
    wr(I_MASK, ST, 8'h05);
    wr(I_MASK, ST, 8'h02);
    rd(I_MASK, v); check("R1 set ORs", 32'(v), 32'h07);
    wr(I_MASK, CL, 8'h01);
    rd(I_MASK, v); check("R1 clear one bit", 32'(v), 32'h06);
    wr(I_MASK, RD, 8'hFF);
    rd(I_MASK, v); check("R1 write to read-back ignored", 32'(v), 32'h06);
    rd({I_MASK[3:0]}, v);
    rd_addr = {I_MASK, ST}; #1;
    check("R1 read at set address returns 0", 32'(rd_data), 0);
    wr(I_MASK, CL, 8'hFF);

    // R11 storage registers
    wr(I_SSEL, ST, 8'hFF);
    rd(I_SSEL, v); check("R11 source-select all ones", 32'(v), 32'hFF);
    wr(I_TEST, ST, 8'h01);
    rd(I_TEST, v); check("R11 test bit set", 32'(v), 32'h01);
    wr(I_TEST, CL, 8'h01);
    rd(I_TEST, v); check("R11 test bit clear", 32'(v), 32'h00);

    // R3 separate latches, independent clear
    wr(I_C0, ST, 8'h01); wr(I_C1, ST, 8'h01);
    @(negedge clk) irq[0] = 1'b1;
    repeat (4) @(negedge clk);
    irq[0] = 1'b0;
    repeat (4) @(negedge clk);
    rd(I_RISE, v); check("R3 rise latched", 32'(v), 32'h01);
    rd(I_FALL, v); check("R3 fall latched", 32'(v), 32'h01);
    wr(I_RISE, ST, 8'hFE);
    rd(I_RISE, v); check("R3 set write to latch ignored", 32'(v), 32'h01);
    wr(I_RISE, CL, 8'h01);
    rd(I_RISE, v); check("R3 rise cleared", 32'(v), 32'h00);
    rd(I_FALL, v); check("R3 fall kept", 32'(v), 32'h01);
    wr(I_FALL, CL, 8'h01);
    // level mode does not capture
    wr(I_C0, ST, 8'h02); wr(I_C2, ST, 8'h02);
    @(negedge clk) irq[1] = 1'b1;
    repeat (4) @(negedge clk);
    irq[1] = 1'b0;
    repeat (4) @(negedge clk);
    rd(I_RISE, v); check("R3 level mode no rise capture", 32'(v), 32'h00);
    rd(I_FALL, v); check("R3 level mode no fall capture", 32'(v), 32'h00);

    // R7 wake independent of mask
    wr(I_C0, ST, 8'h04); wr(I_C2, ST, 8'h04); wr(I_WAKE, ST, 8'h04);
    @(negedge clk) irq[2] = 1'b1;
    repeat (4) @(negedge clk);
    check("R7 wake with mask off", {30'd0, wake, req0 | req1}, 32'h2);
    wr(I_WAKE, CL, 8'h04);
    check("R7 wake cleared", 32'(wake), 0);
    irq[2] = 1'b0;

    // R9 edge beats clear in same cycle
    wr(I_C0, ST, 8'h08);
    repeat (4) @(negedge clk);
    irq[3] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = {I_RISE, CL}; wr_data = 8'h08;
    @(negedge clk);
    wr_en = 1'b0;
    rd(I_RISE, v); check("R9 capture wins over clear", 32'(v), 32'h08);
    wr(I_RISE, CL, 8'h08);
    rd(I_RISE, v); check("R9 later clear works", 32'(v), 32'h00);
    irq[3] = 1'b0;

    // R10 latency: level on line 0, edge on line 1
    wr(I_C0, ST, 8'h30); wr(I_C2, ST, 8'h10);
    wr(I_MASK, ST, 8'h30); wr(I_ASG, ST, 8'h10);
    repeat (4) @(negedge clk);
    irq[4] = 1'b1; irq[5] = 1'b1;
    @(negedge clk);
    check("R10 level after one edge", {30'd0, req0, req1}, 0);
    @(negedge clk);
    check("R10 level after two edges", {30'd0, req0, req1}, 32'h2);
    @(negedge clk);
    check("R10 edge after three edges", {30'd0, req0, req1}, 32'h3);
    irq = '0;

    // Sweep: every source, code and assign value (R2 R4 R5 R6)
    for (int s = 0; s < N; s++) begin
      for (int c = 0; c < 8; c++) begin
        for (int a = 0; a < 2; a++) begin
          @(negedge clk) irq = '0;
          wr(I_C0, CL, 8'hFF); wr(I_C1, CL, 8'hFF); wr(I_C2, CL, 8'hFF);
          wr(I_MASK, CL, 8'hFF); wr(I_ASG, CL, 8'hFF);
          repeat (4) @(negedge clk);
          if (c[0]) wr(I_C0, ST, N'(1 << s));
          if (c[1]) wr(I_C1, ST, N'(1 << s));
          if (c[2]) wr(I_C2, ST, N'(1 << s));
          wr(I_RISE, CL, 8'hFF); wr(I_FALL, CL, 8'hFF);
          if (a == 1) wr(I_ASG, ST, N'(1 << s));
          // R5: still masked, nothing pending
          check($sformatf("R5 masked src%0d code%0d", s, c), {30'd0, req0, req1}, 0);
          wr(I_MASK, ST, N'(1 << s));
          sweep_check(s, c, a[0], 1'b0, 1'b0, 1'b0, "low");
          irq[s] = 1'b1;
          repeat (4) @(negedge clk);
          sweep_check(s, c, a[0], 1'b1, 1'b1, 1'b0, "high");
          wr(I_RISE, CL, N'(1 << s));
          sweep_check(s, c, a[0], 1'b1, 1'b0, 1'b0, "cleared");
          irq[s] = 1'b0;
          repeat (4) @(negedge clk);
          sweep_check(s, c, a[0], 1'b0, 1'b0, 1'b1, "fell");
        end
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule